// File: doc/BRIEF.md
# Register-Commanded Bus Master Bridge

The bridge lets a host that only speaks in 64-bit register writes and reads drive single transactions on a simple on-chip peripheral bus. The host first loads a 64-bit data register, then writes a 64-bit control word. That word carries a fixed tag, a transfer size, a read/write flag, an address-length code and a 32-bit target address. If the word is well formed and the bridge is idle, one single-beat request goes out on the downstream port. It stays there until the target acknowledges it, or until a programmable cycle limit expires.

The host follows progress through a 64-bit status word. It holds a busy flag, a done flag, three separate error fields and a 32-bit read-data field. All fields use MSB-0 numbering: bit 0 is the most significant bit of the word. Sub-word data is kept left-justified at the register side in both directions. On the bus side it is right-justified in the low byte lanes.

Top module: `regcmd_bus_bridge`

## Requirements
- R1: Control-word fields, MSB-0: bits 0–3 hold the tag 0xD, bits 4–7 the byte count, bit 15 is set for a read, bits 23–25 hold the address-length code (4 is used), and bits 32–63 hold the address. When the bridge is idle, a control write with the tag and a byte count of 1, 2 or 4 starts a transaction. On the next cycle `bus_req` is high, `bus_addr` carries the address, `bus_we` is the inverse of the read flag and `bus_size` carries the byte count.
- R2: A control write to an idle bridge with any other tag or byte count starts no bus cycle. On the next cycle the status shows done together with error-group-two bit 53.
- R3: Write data comes from the top of the data register. A 1-byte write drives data-register bits 0–7 (MSB-0) onto `bus_wdata[7:0]`, a 2-byte write drives bits 0–15 onto `bus_wdata[15:0]`, and a 4-byte write drives bits 0–31 onto `bus_wdata[31:0]`. Unused upper lanes are zero.
- R4: After a successful read, status bits 6–37 hold the returned data left-justified. A 1-byte read puts `bus_rdata[7:0]` in bits 6–13, a 2-byte read puts `bus_rdata[15:0]` in bits 6–21, and a 4-byte read puts all 32 bits there. Unfilled bits are zero. The field is zero after writes and after failed reads.
- R5: Status bit 44 (busy) and `bus_req` are high from the cycle after an accepted command until the cycle after the acknowledge. Status bit 52 (done) then sets and busy clears. Busy and done are never both set.
- R6: An acknowledge that comes with `bus_err` completes the transaction with done set and the bus-error field (bits 0–5) equal to 1, which is bit 5 set.
- R7: If no acknowledge arrives, `bus_req` stays high for `tmo_limit`+1 cycles. The bridge then drops it and sets done together with error-group-one bit 45.
- R8: An acknowledge that arrives in the cycle in which the limit expires wins. The transaction completes normally and bit 45 stays clear.
- R9: A control write made while busy is ignored. The request in flight keeps its address and data, and no second transaction follows it.
- R10: After reset, the status word is zero and `bus_req` is low. An accepted command clears done, every error field and the read data.
- R11: Writing the data register while busy does not change `bus_wdata` of the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 64 | Data register write value |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 64 | Control word |
| tmo_limit | input | TMO_W | Timeout limit in cycles |
| status_o | output | 64 | Status word |
| bus_req | output | 1 | Downstream request |
| bus_we | output | 1 | Downstream write (1) or read (0) |
| bus_size | output | 3 | Downstream byte count (1, 2 or 4) |
| bus_addr | output | 32 | Downstream address |
| bus_wdata | output | 32 | Downstream write data, right-justified |
| bus_ack | input | 1 | Downstream acknowledge |
| bus_err | input | 1 | Error response qualifying `bus_ack` |
| bus_rdata | input | 32 | Downstream read data, right-justified |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an acknowledge and timeout expiry. The bench sets a small limit and raises `bus_ack` exactly in the expiring cycle, and it expects done with error-group one clear. The second pair is an acknowledge and a new control write. A command written while the request is still outstanding must leave the address and data on the bus unchanged, and no request may follow the completion. The bench judges this at the bus pins and in the status word.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam logic [3:0] CMD_TAG = 4'hD;

    // LSB-0 positions of the status fields (MSB-0 bit b sits at 63-b)
    localparam int ST_BERR_LO = 58;   // MSB-0 0..5
    localparam int ST_RDAT_LO = 26;   // MSB-0 6..37
    localparam int ST_BUSY    = 19;   // MSB-0 44
    localparam int ST_ERR1_LO = 12;   // MSB-0 45..51
    localparam int ST_DONE    = 11;   // MSB-0 52
    localparam int ST_ERR2_LO = 8;    // MSB-0 53..55

    localparam logic [5:0] BERR_RESP = 6'b000001; // MSB-0 bit 5
    localparam logic [6:0] ERR1_TMO  = 7'b1000000; // MSB-0 bit 45
    localparam logic [2:0] ERR2_CMD  = 3'b100;     // MSB-0 bit 53

    typedef struct packed {
        logic        busy;
        logic        done;
        logic [5:0]  berr;
        logic [6:0]  err1;
        logic [2:0]  err2;
        logic [31:0] rdat;
        logic        wr;
        logic [2:0]  size;
        logic [31:0] addr;
        logic [31:0] wdat;
        logic [31:0] dreg;
    } bridge_state_t;

endpackage

// File: rtl/rcb_cmd_decode.sv
module rcb_cmd_decode (
    input  logic [63:0] word,
    output logic        legal,
    output logic        is_read,
    output logic [2:0]  size,
    output logic [31:0] addr
);
    import rcb_pkg::*;

    logic [3:0] tag_f;
    logic [3:0] size_f;
    logic       unused_bits;

    assign tag_f   = word[63:60];
    assign size_f  = word[59:56];
    assign is_read = word[48];
    assign addr    = word[31:0];
    assign size    = size_f[2:0];
    assign unused_bits = ^{word[55:49], word[47:32]};

    always_comb begin
        legal = 1'b0;
        if (tag_f == CMD_TAG) begin
            legal = (size_f == 4'd1) || (size_f == 4'd2) || (size_f == 4'd4);
        end
    end

endmodule

// File: rtl/rcb_lanes.sv
module rcb_lanes (
    input  logic [2:0]  wr_size,
    input  logic [31:0] wr_src,
    output logic [31:0] wr_lanes,
    input  logic [2:0]  rd_size,
    input  logic [31:0] rd_lanes,
    output logic [31:0] rd_just
);
    always_comb begin
        case (wr_size)
            3'd1:    wr_lanes = {24'b0, wr_src[31:24]};
            3'd2:    wr_lanes = {16'b0, wr_src[31:16]};
            default: wr_lanes = wr_src;
        endcase
        case (rd_size)
            3'd1:    rd_just = {rd_lanes[7:0], 24'b0};
            3'd2:    rd_just = {rd_lanes[15:0], 16'b0};
            default: rd_just = rd_lanes;
        endcase
    end

endmodule

// File: rtl/rcb_timer.sv
module rcb_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/regcmd_bus_bridge.sv
module regcmd_bus_bridge #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_we,
    input  logic [63:0]      data_wdata,
    input  logic             ctl_we,
    input  logic [63:0]      ctl_wdata,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic [63:0]      status_o,
    output logic             bus_req,
    output logic             bus_we,
    output logic [2:0]       bus_size,
    output logic [31:0]      bus_addr,
    output logic [31:0]      bus_wdata,
    input  logic             bus_ack,
    input  logic             bus_err,
    input  logic [31:0]      bus_rdata
);
    import rcb_pkg::*;

    bridge_state_t s_d, s_q;

    logic        cmd_legal;
    logic        cmd_read;
    logic [2:0]  cmd_size;
    logic [31:0] cmd_addr;
    logic [31:0] lane_wdata;
    logic [31:0] lane_rdata;
    logic        tmo_start;
    logic        tmo_hit;
    logic        unused_dlo;

    assign unused_dlo = ^data_wdata[31:0];

    rcb_cmd_decode i_dec (
        .word    (ctl_wdata),
        .legal   (cmd_legal),
        .is_read (cmd_read),
        .size    (cmd_size),
        .addr    (cmd_addr)
    );

    rcb_lanes i_lanes (
        .wr_size  (cmd_size),
        .wr_src   (s_q.dreg),
        .wr_lanes (lane_wdata),
        .rd_size  (s_q.size),
        .rd_lanes (bus_rdata),
        .rd_just  (lane_rdata)
    );

    rcb_timer #(.W(TMO_W)) i_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmo_start),
        .run     (s_q.busy && !bus_ack),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    always_comb begin
        s_d       = s_q;
        tmo_start = 1'b0;
        if (data_we) begin
            s_d.dreg = data_wdata[63:32];
        end
        if (!s_q.busy && ctl_we) begin
            s_d.done = 1'b0;
            s_d.berr = '0;
            s_d.err1 = '0;
            s_d.err2 = '0;
            s_d.rdat = '0;
            if (cmd_legal) begin
                s_d.busy  = 1'b1;
                s_d.wr    = !cmd_read;
                s_d.size  = cmd_size;
                s_d.addr  = cmd_addr;
                s_d.wdat  = cmd_read ? 32'b0 : lane_wdata;
                tmo_start = 1'b1;
            end else begin
                s_d.done = 1'b1;
                s_d.err2 = ERR2_CMD;
            end
        end else if (s_q.busy) begin
            if (bus_ack) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (bus_err) begin
                    s_d.berr = BERR_RESP;
                end else if (!s_q.wr) begin
                    s_d.rdat = lane_rdata;
                end
            end else if (tmo_hit) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.err1 = ERR1_TMO;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        status_o = '0;
        status_o[ST_BERR_LO +: 6]  = s_q.berr;
        status_o[ST_RDAT_LO +: 32] = s_q.rdat;
        status_o[ST_BUSY]          = s_q.busy;
        status_o[ST_ERR1_LO +: 7]  = s_q.err1;
        status_o[ST_DONE]          = s_q.done;
        status_o[ST_ERR2_LO +: 3]  = s_q.err2;
    end

    assign bus_req   = s_q.busy;
    assign bus_we    = s_q.wr;
    assign bus_size  = s_q.size;
    assign bus_addr  = s_q.addr;
    assign bus_wdata = s_q.wdat;

endmodule

// File: rtl/rcb_bridge_chk.sv
module rcb_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic [63:0] ctl_wdata,
    input logic [63:0] status_o,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack
);
    logic cw_good;
    assign cw_good = (ctl_wdata[63:60] == 4'hD) &&
                     ((ctl_wdata[59:56] == 4'd1) || (ctl_wdata[59:56] == 4'd2) ||
                      (ctl_wdata[59:56] == 4'd4));

    // R1
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[19] && ctl_we && cw_good) |=>
        (bus_req && bus_addr == $past(ctl_wdata[31:0]) && bus_we == !$past(ctl_wdata[48])));

    // R2
    reject_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[19] && ctl_we && !cw_good) |=> (!bus_req && status_o[11] && status_o[10]));

    // R5
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req && status_o[11] && !status_o[19]));

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[19] && status_o[11]));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && ctl_we) |=> ($stable(bus_addr) && $stable(bus_wdata)));

    // R7
    tmo_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[18]) |-> $past(bus_req && !bus_ack));

endmodule

bind regcmd_bus_bridge rcb_bridge_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .status_o  (status_o),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/test_regcmd_bus_bridge.sv
module test_regcmd_bus_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int TMO_W = 16;

    typedef struct packed {
        logic        rd;
        logic [3:0]  size;
        logic [31:0] addr;
        logic [63:0] data;
        logic [31:0] resp;
        logic        err;
        logic [3:0]  dly;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'd1, 32'h0000_1000, 64'hA5C3_7711_0000_0000, 32'h0, 1'b0, 4'd0},
        '{1'b0, 4'd2, 32'h2000_0002, 64'hBEEF_1234_5678_9ABC, 32'h0, 1'b0, 4'd2},
        '{1'b0, 4'd4, 32'hDEAD_0004, 64'h1234_5678_FFFF_0000, 32'h0, 1'b0, 4'd1},
        '{1'b1, 4'd1, 32'h0000_0010, 64'h0,                   32'h1234_56C3, 1'b0, 4'd0},
        '{1'b1, 4'd2, 32'h0000_0020, 64'h0,                   32'hAAAA_5A7E, 1'b0, 4'd3},
        '{1'b1, 4'd4, 32'h0F00_0040, 64'h0,                   32'h89AB_CDEF, 1'b0, 4'd1},
        '{1'b1, 4'd4, 32'h0000_0050, 64'h0,                   32'h5555_5555, 1'b1, 4'd0},
        '{1'b0, 4'd2, 32'h0000_0060, 64'hCAFE_0000_0000_0000, 32'h0, 1'b1, 4'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_we = 1'b0;
    logic [63:0]      data_wdata = '0;
    logic             ctl_we = 1'b0;
    logic [63:0]      ctl_wdata = '0;
    logic [TMO_W-1:0] tmo_limit = 16'd100;
    logic [63:0]      status_o;
    logic             bus_req, bus_we;
    logic [2:0]       bus_size;
    logic [31:0]      bus_addr, bus_wdata;
    logic             bus_ack = 1'b0;
    logic             bus_err = 1'b0;
    logic [31:0]      bus_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regcmd_bus_bridge #(.TMO_W(TMO_W)) i_regcmd_bus_bridge (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tmo_limit(tmo_limit),
        .status_o(status_o), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ctl(input logic [3:0] tag, input logic [3:0] sz,
                                           input logic rd, input logic [31:0] a);
        logic [63:0] c = '0;
        c[63:60] = tag;
        c[59:56] = sz;
        c[48]    = rd;
        c[40:38] = 3'd4;
        c[31:0]  = a;
        return c;
    endfunction

    function automatic logic [31:0] exp_w(input logic [3:0] sz, input logic [63:0] d);
        if (sz == 4'd1) return {24'b0, d[63:56]};
        if (sz == 4'd2) return {16'b0, d[63:48]};
        return d[63:32];
    endfunction

    function automatic logic [31:0] exp_r(input logic [3:0] sz, input logic [31:0] r);
        if (sz == 4'd1) return {r[7:0], 24'b0};
        if (sz == 4'd2) return {r[15:0], 16'b0};
        return r;
    endfunction

    task automatic write_data(input logic [63:0] d);
        @(negedge clk); data_we = 1'b1; data_wdata = d;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic write_ctl(input logic [63:0] c);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = c;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic pulse_ack(input logic e, input logic [31:0] r);
        bus_ack = 1'b1; bus_err = e; bus_rdata = r;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    endtask

    task automatic run_vec(input vec_t v);
        write_data(v.data);
        write_ctl(mk_ctl(4'hD, v.size, v.rd, v.addr));
        check("R1 bus_req", bus_req, 1);
        check("R1 bus_addr", bus_addr, v.addr);
        check("R1 bus_we", bus_we, !v.rd);
        check("R1 bus_size", bus_size, v.size[2:0]);
        if (!v.rd) check("R3 bus_wdata", bus_wdata, exp_w(v.size, v.data));
        check("R5 busy", status_o[19], 1);
        check("R10 cleared done", status_o[11], 0);
        for (int k = 0; k < int'(v.dly); k++) @(negedge clk);
        check("R5 still busy before ack", status_o[19], 1);
        pulse_ack(v.err, v.resp);
        check("R5 busy cleared", status_o[19], 0);
        check("R5 done set", status_o[11], 1);
        check("R5 req dropped", bus_req, 0);
        check("R6 bus error field", status_o[63:58], v.err ? 6'b000001 : 6'b0);
        check("R4 read data", status_o[57:26], (v.rd && !v.err) ? exp_r(v.size, v.resp) : 32'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset status", status_o, 64'b0);
        check("R10 reset req", bus_req, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R2: bad tag, then bad size
        write_ctl(mk_ctl(4'hC, 4'd4, 1'b0, 32'h100));
        check("R2 bad tag no req", bus_req, 0);
        check("R2 bad tag done", status_o[11], 1);
        check("R2 bad tag err2", status_o[10:8], 3'b100);
        write_ctl(mk_ctl(4'hD, 4'd3, 1'b1, 32'h104));
        check("R2 bad size no req", bus_req, 0);
        check("R2 bad size err2", status_o[10:8], 3'b100);
        check("R2 bad size busy", status_o[19], 0);

        // R7: timeout with limit 3
        tmo_limit = 16'd3;
        write_ctl(mk_ctl(4'hD, 4'd4, 1'b1, 32'h200));
        check("R10 err2 cleared on accept", status_o[10:8], 3'b0);
        repeat (3) @(negedge clk);
        check("R7 req held until limit", bus_req, 1);
        @(negedge clk);
        check("R7 req dropped", bus_req, 0);
        check("R7 done", status_o[11], 1);
        check("R7 err1 bit45", status_o[18:12], 7'b1000000);

        // R8: ack in expiring cycle
        write_ctl(mk_ctl(4'hD, 4'd1, 1'b1, 32'h300));
        check("R10 err1 cleared on accept", status_o[18:12], 7'b0);
        repeat (3) @(negedge clk);
        pulse_ack(1'b0, 32'h0000_0042);
        check("R8 done", status_o[11], 1);
        check("R8 no timeout", status_o[18:12], 7'b0);
        check("R8 data", status_o[57:26], 32'h4200_0000);
        tmo_limit = 16'd100;

        // R9: control write while busy
        write_ctl(mk_ctl(4'hD, 4'd4, 1'b1, 32'h0000_0A00));
        write_ctl(mk_ctl(4'hD, 4'd2, 1'b0, 32'h0000_0B00));
        check("R9 addr kept", bus_addr, 32'h0000_0A00);
        check("R9 we kept", bus_we, 0);
        pulse_ack(1'b0, 32'h0102_0304);
        check("R9 first completes", status_o[57:26], 32'h0102_0304);
        @(negedge clk);
        check("R9 no second req", bus_req, 0);

        // R9 + R5: control write in the same cycle as the ack
        write_ctl(mk_ctl(4'hD, 4'd4, 1'b0, 32'h0000_0C00));
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = mk_ctl(4'hD, 4'd4, 1'b0, 32'h0000_0D00);
        pulse_ack(1'b0, 32'h0);
        ctl_we = 1'b0;
        check("R9 same-cycle ctl ignored", bus_req, 0);
        check("R9 same-cycle done", status_o[11], 1);

        // R11: data write while busy
        write_data(64'h1111_2222_0000_0000);
        write_ctl(mk_ctl(4'hD, 4'd4, 1'b0, 32'h0000_0E00));
        write_data(64'h9999_8888_0000_0000);
        check("R11 wdata kept", bus_wdata, 32'h1111_2222);
        pulse_ack(1'b0, 32'h0);
        check("R11 done", status_o[11], 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule